// File: doc/BRIEF.md
# Dual-Scheme Memory Paging Unit

This block maps a 16-bit processor address onto one of four physical memories: a boot ROM, a main (HOME) RAM, and two overlay RAMs called DOCK and EX. Two paging schemes are combined. The first is a per-8kB overlay. Each of the eight 8kB sections of the address space can be replaced by the matching 8kB slice of whichever overlay RAM the control register selects. Only one overlay RAM is ever mapped at a time. The second is a 16kB bank selector for the HOME RAM. It follows the usual 128K arrangement, except that the window at 0x8000 holds a ninth, extra bank. The HOME RAM is therefore 144kB.

Three paging registers sit at fully decoded I/O addresses, and each returns its stored byte on a read. For every processor address, the block outputs a memory select, a physical address, a contention flag for the wait-state logic, and the screen-bank choice for the display fetch. The display fetch always reads HOME RAM, whatever overlay covers the screen window.

Top module: `dual_page_map`

## Requirements
- R1: At reset all three registers clear to 0x00. With no overlay, address 0x0000 then selects ROM (`mem_sel` = 0) at physical address 0.
- R2: The overlay register (I/O 0x00F4), the control register (I/O 0x00FF) and the bank register (I/O 0x7FFD) each store a write and return it on `io_rdata` with `io_hit` = 1. Any other 16-bit I/O address, including 0x01F4, 0x00FE and 0x7FFC, gives `io_hit` = 0 and `io_rdata` = 0, and a write to it changes no register.
- R3: When no overlay applies, 0x0000-0x3FFF selects ROM. The physical address is {page, addr[13:0]}, and page is bit 4 of the bank register.
- R4: When no overlay applies, `mem_sel` = 1 (HOME) and `mem_addr` = bank*16384 + addr[13:0]. The bank is 5 for 0x4000-0x7FFF, the extra bank 8 for 0x8000-0xBFFF, and bits 2:0 of the bank register for 0xC000-0xFFFF.
- R5: If bit n of the overlay register is set, section n (addr[15:13] = n) selects DOCK (`mem_sel` = 2) when control bit 7 is 0, or EX (`mem_sel` = 3) when it is 1. In both cases `mem_addr` = addr.
- R6: When the top bank number is odd, overlay bit 2 also overlays section 6 and overlay bit 3 also overlays section 7. When the top bank number is even, bits 2 and 3 have no effect on the top window.
- R7: `contended` is 1 exactly when `mem_sel` = HOME and the HOME bank is odd. This covers the screen bank 5 and odd top banks. Banks 8 and even top banks are not contended.
- R8: `video_shadow` equals bit 3 of the bank register and does not depend on the overlay or control registers.
- R9: Once bit 5 of the bank register is 1, further writes to 0x7FFD are ignored until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O port address |
| io_wr | input | 1 | I/O write strobe |
| io_wdata | input | 8 | I/O write data |
| io_hit | output | 1 | io_addr is one of the three register ports |
| io_rdata | output | 8 | Contents of the addressed register, else 0 |
| cpu_addr | input | 16 | Processor memory address |
| mem_sel | output | 2 | 0 ROM, 1 HOME, 2 DOCK, 3 EX |
| mem_addr | output | 18 | Physical address inside the selected memory |
| contended | output | 1 | Access hits an odd HOME bank |
| video_shadow | output | 1 | Display fetch uses the shadow screen bank |

## Verification
The bench probes the top window with overlay bits 2 and 3 set, once under odd and once under even top banks. A design that leaked those bits unconditionally, or never leaked them, would send 0xC000-0xFFFF to the wrong memory. It writes to near-miss I/O addresses and then reads every register back. A partly decoded port would show up as a corrupted register or a false `io_hit`. Further cases cover the extra bank at 0x8000 (a design that kept bank 2 there would give the wrong physical address), the write lock, the DOCK/EX switch, and a screen overlay that must leave `video_shadow` unchanged.

// File: rtl/dual_page_map.sv
module dual_page_map #(
  parameter logic [15:0] OVL_PORT  = 16'h00F4,
  parameter logic [15:0] CTL_PORT  = 16'h00FF,
  parameter logic [15:0] BANK_PORT = 16'h7FFD
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] io_addr,
  input  logic        io_wr,
  input  logic [7:0]  io_wdata,
  output logic        io_hit,
  output logic [7:0]  io_rdata,
  input  logic [15:0] cpu_addr,
  output logic [1:0]  mem_sel,
  output logic [17:0] mem_addr,
  output logic        contended,
  output logic        video_shadow
);
  localparam logic [1:0] SEL_ROM = 2'd0, SEL_HOME = 2'd1, SEL_DOCK = 2'd2, SEL_EX = 2'd3;

  logic [7:0] ovl_q, ctl_q, bank_q;
  logic [3:0] home_bank;
  logic [2:0] sec;
  logic       use_ovl, leak;

  wire hit_ovl  = (io_addr == OVL_PORT);
  wire hit_ctl  = (io_addr == CTL_PORT);
  wire hit_bank = (io_addr == BANK_PORT);
  wire locked   = bank_q[5];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovl_q  <= '0;
      ctl_q  <= '0;
      bank_q <= '0;
    end else if (io_wr) begin
      if (hit_ovl)              ovl_q  <= io_wdata;
      if (hit_ctl)              ctl_q  <= io_wdata;
      if (hit_bank && !locked)  bank_q <= io_wdata;
    end
  end

  assign io_hit   = hit_ovl | hit_ctl | hit_bank;
  assign io_rdata = hit_ovl ? ovl_q : hit_ctl ? ctl_q : hit_bank ? bank_q : 8'h00;

  assign sec  = cpu_addr[15:13];
  assign leak = bank_q[0] && ((sec == 3'd6 && ovl_q[2]) || (sec == 3'd7 && ovl_q[3]));
  assign use_ovl = ovl_q[sec] | leak;

  always_comb begin
    case (cpu_addr[15:14])
      2'd1:    home_bank = 4'd5;
      2'd2:    home_bank = 4'd8;
      default: home_bank = {1'b0, bank_q[2:0]};
    endcase
  end

  always_comb begin
    if (use_ovl) begin
      mem_sel  = ctl_q[7] ? SEL_EX : SEL_DOCK;
      mem_addr = {2'b00, cpu_addr};
    end else if (cpu_addr[15:14] == 2'd0) begin
      mem_sel  = SEL_ROM;
      mem_addr = {3'b000, bank_q[4], cpu_addr[13:0]};
    end else begin
      mem_sel  = SEL_HOME;
      mem_addr = {home_bank, cpu_addr[13:0]};
    end
  end

  assign contended    = (mem_sel == SEL_HOME) && home_bank[0];
  assign video_shadow = bank_q[3];

  assert_lock_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && io_wr && io_addr == BANK_PORT) |=> $stable(bank_q));

  assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == OVL_PORT) |=> (ovl_q == $past(io_wdata)));

  assert_miss_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr != OVL_PORT && io_addr != CTL_PORT && io_addr != BANK_PORT)
      |=> ($stable(ovl_q) && $stable(ctl_q) && $stable(bank_q)));

  assert_contend_home_R7: assert property (@(posedge clk) disable iff (!rst_n)
    contended |-> (mem_sel == SEL_HOME));

  assert_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_q[7] && mem_sel == SEL_DOCK) && !(!ctl_q[7] && mem_sel == SEL_EX));

  assert_rom_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_sel == SEL_ROM) |-> (cpu_addr[15:14] == 2'd0));
endmodule

// File: tb/sim_dual_page_map.sv
module sim_dual_page_map;
  logic        clk = 0, rst_n = 0, io_wr = 0;
  logic [15:0] io_addr = 0, cpu_addr = 0;
  logic [7:0]  io_wdata = 0;
  logic        io_hit, contended, video_shadow;
  logic [7:0]  io_rdata;
  logic [1:0]  mem_sel;
  logic [17:0] mem_addr;

  dual_page_map u0 (.clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_hit(io_hit), .io_rdata(io_rdata), .cpu_addr(cpu_addr),
    .mem_sel(mem_sel), .mem_addr(mem_addr), .contended(contended), .video_shadow(video_shadow));

  always #2 clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;
  int m_ovl = 0, m_ctl = 0, m_bank = 0;
  string tag = "R1";

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    int a, sec, win, topb, ov, e_sel, e_addr, e_cont, e_hit, e_rd, bank;
    a = cpu_addr; sec = a / 8192; win = a / 16384; topb = m_bank % 8;
    ov = (m_ovl >> sec) & 1;
    if (topb % 2 == 1 && ((sec == 6 && (m_ovl & 4) != 0) || (sec == 7 && (m_ovl & 8) != 0))) ov = 1;
    e_cont = 0;
    if (ov == 1) begin
      e_sel = (m_ctl >= 128) ? 3 : 2; e_addr = a;
    end else if (win == 0) begin
      e_sel = 0; e_addr = ((m_bank >> 4) & 1) * 16384 + a % 16384;
    end else begin
      bank = (win == 1) ? 5 : (win == 2) ? 8 : topb;
      e_sel = 1; e_addr = bank * 16384 + a % 16384; e_cont = bank % 2;
    end
    e_hit = (io_addr == 16'h00F4 || io_addr == 16'h00FF || io_addr == 16'h7FFD);
    e_rd = (io_addr == 16'h00F4) ? m_ovl : (io_addr == 16'h00FF) ? m_ctl :
           (io_addr == 16'h7FFD) ? m_bank : 0;
    chk("mem_sel", mem_sel, e_sel);
    chk("mem_addr", mem_addr, e_addr);
    chk("contended", contended, e_cont);
    chk("io_hit", io_hit, e_hit);
    chk("io_rdata", io_rdata, e_rd);
    chk("video_shadow", video_shadow, (m_bank >> 3) & 1);
  endtask

  task automatic cyc(bit wr, logic [15:0] ioa, logic [7:0] wd, logic [15:0] ca);
    io_wr = wr; io_addr = ioa; io_wdata = wd; cpu_addr = ca;
    @(posedge clk);
    if (wr && rst_n) begin
      if (ioa == 16'h00F4) m_ovl = wd;
      if (ioa == 16'h00FF) m_ctl = wd;
      if (ioa == 16'h7FFD && (m_bank & 32) == 0) m_bank = wd;
    end
    @(negedge clk);
    compare();
  endtask

  task automatic do_reset();
    rst_n = 0; io_wr = 0;
    repeat (2) @(posedge clk);
    m_ovl = 0; m_ctl = 0; m_bank = 0;
    @(negedge clk); rst_n = 1;
  endtask

  task automatic sweep();
    for (int s = 0; s < 8; s++) cyc(0, 16'h00F4, 0, 16'(s * 8192 + 37));
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    tag = "R1";
    cyc(0, 16'h00F4, 0, 16'h0000);
    cyc(0, 16'h00FF, 0, 16'h0000);
    cyc(0, 16'h7FFD, 0, 16'h0000);

    tag = "R2";
    cyc(1, 16'h00F4, 8'h5A, 16'h0000);
    cyc(1, 16'h01F4, 8'hFF, 16'h0000);
    cyc(0, 16'h00F4, 0, 16'h0000);
    cyc(1, 16'h00FE, 8'h80, 16'h1000);
    cyc(1, 16'h7FFC, 8'h07, 16'hC000);
    cyc(0, 16'h00FF, 0, 16'hC000);
    cyc(0, 16'h7FFD, 0, 16'hC000);
    cyc(1, 16'h00FF, 8'h3C, 16'h0000);
    cyc(0, 16'h00FF, 0, 16'h0000);
    cyc(1, 16'h00F4, 8'h00, 16'h0000);
    cyc(1, 16'h00FF, 8'h00, 16'h0000);

    tag = "R3";
    cyc(1, 16'h7FFD, 8'h10, 16'h0000);
    cyc(0, 16'h0000, 0, 16'h3FFF);
    cyc(1, 16'h7FFD, 8'h00, 16'h2ABC);

    tag = "R4";
    for (int b = 0; b < 8; b++) begin
      cyc(1, 16'h7FFD, 8'(b), 16'h4001);
      cyc(0, 16'h7FFD, 0, 16'h8123);
      cyc(0, 16'h7FFD, 0, 16'hC456);
      cyc(0, 16'h7FFD, 0, 16'hFFFF);
    end

    tag = "R5";
    cyc(1, 16'h7FFD, 8'h00, 16'h0000);
    for (int c = 0; c < 2; c++) begin
      cyc(1, 16'h00FF, 8'(c * 128), 16'h0000);
      for (int n = 0; n < 8; n++) begin
        cyc(1, 16'h00F4, 8'(1 << n), 16'h0000);
        sweep();
      end
    end
    cyc(1, 16'h00F4, 8'hFF, 16'h0000);
    sweep();

    tag = "R6";
    cyc(1, 16'h00FF, 8'h00, 16'h0000);
    cyc(1, 16'h00F4, 8'h0C, 16'h0000);
    for (int b = 0; b < 8; b++) begin
      cyc(1, 16'h7FFD, 8'(b), 16'hC010);
      cyc(0, 16'h0000, 0, 16'hE010);
    end
    cyc(1, 16'h00F4, 8'h04, 16'h0000);
    cyc(1, 16'h7FFD, 8'h03, 16'hC000);
    cyc(0, 16'h0000, 0, 16'hE000);
    cyc(1, 16'h00F4, 8'h08, 16'hC000);
    cyc(0, 16'h0000, 0, 16'hE000);

    tag = "R7";
    cyc(1, 16'h00F4, 8'h00, 16'h4000);
    for (int b = 0; b < 8; b++) begin
      cyc(1, 16'h7FFD, 8'(b), 16'h5000);
      cyc(0, 16'h0000, 0, 16'h9000);
      cyc(0, 16'h0000, 0, 16'hD000);
      cyc(0, 16'h0000, 0, 16'h1000);
    end

    tag = "R8";
    cyc(1, 16'h7FFD, 8'h08, 16'h4000);
    cyc(1, 16'h00F4, 8'h30, 16'h4000);
    cyc(1, 16'h00FF, 8'h80, 16'h6000);
    cyc(1, 16'h7FFD, 8'h00, 16'h4000);
    cyc(1, 16'h00F4, 8'h00, 16'h4000);
    cyc(1, 16'h00FF, 8'h00, 16'h4000);

    tag = "R9";
    cyc(1, 16'h7FFD, 8'h23, 16'hC000);
    cyc(1, 16'h7FFD, 8'h16, 16'hC000);
    cyc(0, 16'h7FFD, 0, 16'h0000);
    cyc(1, 16'h7FFD, 8'h00, 16'hC000);
    cyc(0, 16'h7FFD, 0, 16'hC000);

    tag = "R1";
    cyc(1, 16'h00F4, 8'hFF, 16'h8000);
    do_reset();
    cyc(0, 16'h7FFD, 0, 16'h0000);
    cyc(0, 16'h00F4, 0, 16'hC000);
    cyc(1, 16'h7FFD, 8'h05, 16'hC000);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule